// File: doc/BRIEF.md
# Motion-Search Coprocessor Bus Bridge

This block is a 32-bit APB slave that lets a host processor drive a motion-search coprocessor. The coprocessor works on 16x16 macroblocks over a 32x32 search area. The bridge decodes a 256-byte window. It holds a control word that the host changes only through separate write-one-to-set and write-one-to-clear registers. Two control bits drive the coprocessor enable and reset pins. A status register reports a sticky completion flag and a busy indication.

The coprocessor's internal memory banks are not mapped onto the bus. The host writes a location into an address register. Each write to the data-in register then becomes a request/grant write cycle on the coprocessor port, and each read of the data-out register becomes a request/grant read cycle. The APB transfer is held with PREADY low until the grant has been seen. Writes advance the address by one, so firmware and pixel blocks upload as a stream. When the coprocessor signals completion, the bridge captures its best-match motion vector and SAD. These stay readable until the next completion.

Top module: `me_apb_bridge`

## Requirements
- R1: After reset the control word, status, address register and result registers read zero; cp_en, cp_rst and cp_req are low; idle transfers complete with no wait state.
- R2: A write to offset 0x04 sets every control bit whose data bit is 1 and leaves the others. Offset 0x0C reads the control word. Bit 0 drives cp_en and bit 1 drives cp_rst.
- R3: A write to offset 0x08 clears every control bit whose data bit is 1 and leaves the others.
- R4: Status offset 0x00 bit 0 becomes 1 once cp_done is seen. It stays 1 until a write to 0x08 has data bit 0 set; clear writes with bit 0 at zero leave it. Status bit 1 is 1 while a coprocessor memory cycle is pending.
- R5: When cp_done is high, cp_mvx, cp_mvy and cp_sad are captured. They read, zero-extended, at 0x30, 0x34 and 0x38, and stay unchanged while cp_done is low.
- R6: A write to 0x28 raises cp_req with cp_wr=1, cp_addr equal to the address register and cp_wdata equal to the written word. The request is held until cp_gnt. The APB access shows PREADY low for exactly L+3 sampled access cycles, where L is the number of request cycles before the grant is raised.
- R7: Offset 0x24 holds the coprocessor address, written and read directly. Each granted write increments it by one, wrapping at 2^AW.
- R8: A read of 0x2C raises cp_req with cp_wr=0, stalls for the same L+3 cycles, returns the cp_rdata present at the grant, and leaves the address register unchanged.
- R9: Unused offsets, reads of 0x28, and writes to 0x00, 0x0C, 0x2C, 0x30, 0x34 and 0x38 complete with no wait state. Any such read returns zero when the register is unused, and none of these writes changes state. PSLVERR is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | Byte offset within window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Error response, always low |
| cp_en | output | 1 | Coprocessor enable (control bit 0) |
| cp_rst | output | 1 | Coprocessor reset (control bit 1) |
| cp_req | output | 1 | Memory cycle request |
| cp_wr | output | 1 | 1 = write strobe, 0 = output enable |
| cp_addr | output | AW | Coprocessor memory address |
| cp_wdata | output | 32 | Word to write |
| cp_rdata | input | 32 | Word read back |
| cp_gnt | input | 1 | Memory cycle grant |
| cp_done | input | 1 | Search complete |
| cp_mvx | input | RW | Best motion vector X |
| cp_mvy | input | RW | Best motion vector Y |
| cp_sad | input | RW | Best-match SAD |

## Verification
Register writes take effect at the edge that completes the transfer, and the next transfer reads them back. Result capture is visible one edge after cp_done. That is always before the next APB read, which the bench starts at least two edges later. For memory transfers the grant model in the bench delays the grant by a chosen latency L. The bench counts the PREADY-low access cycles, sampled at falling edges, and compares that count with L+3. It reads data only in the cycle where PREADY is sampled high.

// File: rtl/me_apb_bridge.sv
module me_apb_bridge #(
  parameter int AW = 12,
  parameter int CW = 8,
  parameter int RW = 16
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [7:0]    paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          cp_en,
  output logic          cp_rst,
  output logic          cp_req,
  output logic          cp_wr,
  output logic [AW-1:0] cp_addr,
  output logic [31:0]   cp_wdata,
  input  logic [31:0]   cp_rdata,
  input  logic          cp_gnt,
  input  logic          cp_done,
  input  logic [RW-1:0] cp_mvx,
  input  logic [RW-1:0] cp_mvy,
  input  logic [RW-1:0] cp_sad
);
  localparam logic [5:0] I_ST = 6'd0, I_SET = 6'd1, I_CLR = 6'd2, I_CTL = 6'd3;
  localparam logic [5:0] I_ADR = 6'd9, I_DIN = 6'd10, I_DOUT = 6'd11;
  localparam logic [5:0] I_MVX = 6'd12, I_MVY = 6'd13, I_SAD = 6'd14;

  logic [CW-1:0] ctrl;
  logic [AW-1:0] addr;
  logic [31:0]   wd_q, rd_q;
  logic [RW-1:0] rx, ry, rs;
  logic          busy, ack, wr_q, done_f;

  wire [5:0] widx    = paddr[7:2];
  wire       acc     = psel & penable;
  wire       mem_hit = acc & ((pwrite & (widx == I_DIN)) | (~pwrite & (widx == I_DOUT)));
  wire       start   = mem_hit & ~busy & ~ack;
  wire       wr_cyc  = acc & pwrite & pready;
  wire       clr_done = wr_cyc & (widx == I_CLR) & pwdata[0];

  assign pready   = ~mem_hit | ack;
  assign pslverr  = 1'b0;
  assign cp_en    = ctrl[0];
  assign cp_rst   = ctrl[1];
  assign cp_req   = busy;
  assign cp_wr    = wr_q;
  assign cp_addr  = addr;
  assign cp_wdata = wd_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl <= '0; addr <= '0; wd_q <= '0; rd_q <= '0;
      rx <= '0; ry <= '0; rs <= '0;
      busy <= 1'b0; ack <= 1'b0; wr_q <= 1'b0; done_f <= 1'b0;
    end else begin
      ack <= busy & cp_gnt;
      if (start) begin
        busy <= 1'b1;
        wr_q <= pwrite;
        wd_q <= pwdata;
      end else if (busy && cp_gnt) begin
        busy <= 1'b0;
        if (wr_q) addr <= addr + 1'b1;
        else      rd_q <= cp_rdata;
      end
      if (wr_cyc && widx == I_ADR) addr <= pwdata[AW-1:0];
      if (wr_cyc && widx == I_SET) ctrl <= ctrl | pwdata[CW-1:0];
      if (wr_cyc && widx == I_CLR) ctrl <= ctrl & ~pwdata[CW-1:0];
      if (cp_done) done_f <= 1'b1;
      else if (clr_done) done_f <= 1'b0;
      if (cp_done) begin
        rx <= cp_mvx; ry <= cp_mvy; rs <= cp_sad;
      end
    end
  end

  always_comb begin
    case (widx)
      I_ST:    prdata = {30'd0, busy, done_f};
      I_CTL:   prdata = {{(32-CW){1'b0}}, ctrl};
      I_ADR:   prdata = {{(32-AW){1'b0}}, addr};
      I_DOUT:  prdata = rd_q;
      I_MVX:   prdata = {{(32-RW){1'b0}}, rx};
      I_MVY:   prdata = {{(32-RW){1'b0}}, ry};
      I_SAD:   prdata = {{(32-RW){1'b0}}, rs};
      default: prdata = 32'd0;
    endcase
  end

  AST_SET_BITS: assert property (@(posedge pclk) disable iff (!presetn)
    wr_cyc && widx == I_SET |=> (ctrl & $past(pwdata[CW-1:0])) == $past(pwdata[CW-1:0])); // R2
  AST_CLR_BITS: assert property (@(posedge pclk) disable iff (!presetn)
    wr_cyc && widx == I_CLR |=> (ctrl & $past(pwdata[CW-1:0])) == '0); // R3
  AST_DONE_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
    done_f && !clr_done |=> done_f); // R4
  AST_RES_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    !cp_done |=> $stable(rx) && $stable(ry) && $stable(rs)); // R5
  AST_REQ_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    cp_req && !cp_gnt |=> cp_req && $stable(cp_addr) && $stable(cp_wr)); // R6
  AST_GNT_READY: assert property (@(posedge pclk) disable iff (!presetn)
    cp_req && cp_gnt |=> pready && !cp_req); // R6
  AST_ADDR_STEP: assert property (@(posedge pclk) disable iff (!presetn)
    cp_req && cp_gnt && cp_wr |=> cp_addr == $past(cp_addr) + 1'b1); // R7
  AST_RD_KEEP_ADDR: assert property (@(posedge pclk) disable iff (!presetn)
    cp_req && cp_gnt && !cp_wr |=> $stable(cp_addr)); // R8
endmodule

// File: tb/test_me_apb_bridge.sv
`timescale 1ns/100ps
module test_me_apb_bridge;
  localparam int AW = 6, CW = 8, RW = 16;
  logic clk = 1'b0, rstn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata, cp_wdata, cp_rdata;
  logic pready, pslverr, cp_en, cp_rst, cp_req, cp_wr, cp_done = 0;
  logic cp_gnt = 0;
  logic [AW-1:0] cp_addr;
  logic [RW-1:0] mvx = 0, mvy = 0, sad = 0;
  logic [31:0] mem [64];
  int lat = 0, cnt = 0, total = 0, bad = 0;

  always #2.5 clk = ~clk;

  me_apb_bridge #(.AW(AW), .CW(CW), .RW(RW)) i_me_apb_bridge (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .cp_en(cp_en), .cp_rst(cp_rst), .cp_req(cp_req), .cp_wr(cp_wr), .cp_addr(cp_addr),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_gnt(cp_gnt), .cp_done(cp_done),
    .cp_mvx(mvx), .cp_mvy(mvy), .cp_sad(sad));

  assign cp_rdata = mem[cp_addr];
  always @(posedge clk) begin
    if (cp_req && !cp_gnt) begin
      if (cnt >= lat) begin
        cp_gnt <= 1'b1; cnt <= 0;
        if (cp_wr) mem[cp_addr] <= cp_wdata;
      end else cnt <= cnt + 1;
    end else cp_gnt <= 1'b0;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int waits);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1; waits = 0;
    #1;
    while (!pready) begin
      waits++;
      @(negedge clk); #1;
    end
    rd = prdata;
    if (pslverr !== 1'b0) chk("R9 pslverr", {31'd0, pslverr}, 32'd0);
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] x; int n;
    xfer(1'b1, a, d, x, n);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    int n;
    xfer(1'b0, a, 32'd0, v, n);
  endtask

  task automatic pulse_done(input logic [15:0] x, input logic [15:0] y, input logic [15:0] s);
    @(negedge clk);
    mvx = x; mvy = y; sad = s; cp_done = 1;
    @(negedge clk);
    cp_done = 0; mvx = ~x; mvy = ~y; sad = ~s;
  endtask

  initial begin
    #900000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, d;
    logic [7:0] c;
    int n;
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rstn = 1;
    // R1 reset state
    chk("R1 cp_en", {31'd0, cp_en}, 0);
    chk("R1 cp_rst", {31'd0, cp_rst}, 0);
    chk("R1 cp_req", {31'd0, cp_req}, 0);
    xfer(1'b0, 8'h00, 0, v, n); chk("R1 status", v, 0); chk("R1 waits", n, 0);
    rd(8'h0C, v); chk("R1 ctrl", v, 0);
    rd(8'h24, v); chk("R1 addr", v, 0);
    rd(8'h30, v); chk("R1 mvx", v, 0);
    rd(8'h38, v); chk("R1 sad", v, 0);

    // R2 / R3 control sweep
    c = 0;
    for (int k = 0; k < 256; k++) begin
      wr(8'h04, 32'hFFFF_FF00 | k);
      c = c | k[7:0];
      rd(8'h0C, v); chk("R2 set", v, {24'd0, c});
      chk("R2 cp_en", {31'd0, cp_en}, {31'd0, c[0]});
      chk("R2 cp_rst", {31'd0, cp_rst}, {31'd0, c[1]});
      d = (k * 37 + 11) & 255;
      wr(8'h08, d);
      c = c & ~d[7:0];
      rd(8'h0C, v); chk("R3 clr", v, {24'd0, c});
    end
    wr(8'h08, 32'hFF);

    // R4 / R5 completion and results
    for (int k = 0; k < 4; k++) begin
      pulse_done(16'h1234 + k * 16'h0101, 16'hF00D - k, 16'h8000 >> k);
      rd(8'h00, v); chk("R4 done set", v, 1);
      rd(8'h30, v); chk("R5 mvx", v, {16'd0, 16'h1234 + k * 16'h0101});
      rd(8'h34, v); chk("R5 mvy", v, {16'd0, 16'hF00D - k});
      rd(8'h38, v); chk("R5 sad", v, {16'd0, 16'h8000 >> k});
      repeat (3) @(negedge clk);
      rd(8'h30, v); chk("R5 hold", v, {16'd0, 16'h1234 + k * 16'h0101});
      wr(8'h08, 32'hFFFF_FFFE);
      rd(8'h00, v); chk("R4 keep", v, 1);
      wr(8'h08, 32'h1);
      rd(8'h00, v); chk("R4 clear", v, 0);
    end

    // R6 / R7 uploads with varied grant latency
    wr(8'h24, 5);
    for (int i = 0; i < 12; i++) begin
      lat = i % 4;
      d = 32'hA500_0000 ^ (i * 32'h0101_0101) + i;
      xfer(1'b1, 8'h28, d, v, n);
      chk("R6 wait", n, lat + 3);
      chk("R6 mem", mem[5 + i], d);
      rd(8'h24, v); chk("R7 incr", v, 6 + i);
    end
    wr(8'h24, 63);
    wr(8'h28, 32'hDEAD_BEEF);
    chk("R6 mem63", mem[63], 32'hDEAD_BEEF);
    rd(8'h24, v); chk("R7 wrap", v, 0);

    // R8 read-back
    for (int i = 0; i < 12; i++) begin
      lat = (i * 3) % 5;
      wr(8'h24, 5 + i);
      xfer(1'b0, 8'h2C, 0, v, n);
      chk("R8 data", v, 32'hA500_0000 ^ (i * 32'h0101_0101) + i);
      chk("R8 wait", n, lat + 3);
      rd(8'h24, v); chk("R8 addr", v, 5 + i);
    end

    // R9 unused offsets and ignored writes
    wr(8'h04, 32'h5A); wr(8'h24, 7);
    for (int k = 0; k < 64; k++) begin
      if (!(k inside {1, 2, 9, 10, 11})) begin
        xfer(1'b1, 8'(k * 4), 32'hFFFF_FFFF, v, n);
        chk("R9 wr wait", n, 0);
        if (!(k inside {0, 3, 12, 13, 14})) begin
          xfer(1'b0, 8'(k * 4), 0, v, n);
          chk("R9 rd zero", v, 0); chk("R9 rd wait", n, 0);
        end
      end
    end
    xfer(1'b1, 8'h2C, 32'h1, v, n); chk("R9 dout wr wait", n, 0);
    xfer(1'b0, 8'h28, 0, v, n); chk("R9 din rd", v, 0); chk("R9 din wait", n, 0);
    chk("R9 no req", {31'd0, cp_req}, 0);
    rd(8'h0C, v); chk("R9 ctrl kept", v, 32'h5A);
    rd(8'h24, v); chk("R9 addr kept", v, 7);
    rd(8'h00, v); chk("R9 status kept", v, 0);
    rd(8'h30, v); chk("R9 mvx kept", v, {16'd0, 16'h1234 + 3 * 16'h0101});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule